// File: doc/BRIEF.md
# Serial ADC Host Frame Controller

This block sits on the host side of a three-wire link to a 12-bit sampling converter: an active-low select, a serial clock that the host drives, and one data line from the converter. A conversion request opens a frame. The block lowers the select and toggles the serial clock from a divided system clock. It shifts in a 14-bit word, drops the two leading framing zeros and presents the 12-bit straight-binary code with a one-cycle valid strobe. If either leading bit arrives as one, an error flag accompanies the data.

Offset-calibration frames are longer and use a slower serial clock. One runs on its own right after reset. This frame has 16 falling edges and returns no data. Others run on command during operation. These have 32 falling edges: they deliver a conversion in their first 14 bit times and calibrate in the rest. A calibration command that arrives during a frame is held and issued once that frame and its acquisition gap are over.

All timing is counted in system clocks. The parameters are the half-period of each serial clock rate, the select-to-first-edge setup, the last-edge-to-deselect hold and the deselect (acquisition) gap. At elaboration these are checked against the nanosecond limits: a 32 MHz ceiling for conversion frames, 16 MHz for calibration frames, 12 ns setup, 10 ns hold and 90 ns acquisition.

Top module: `adc_frame_ctrl`

## Requirements
- R1: During and right after reset, sel_n and ser_clk are high, result_valid and frame_err are low and busy is high.
- R2: The first frame after reset is a calibration frame of exactly 16 ser_clk falling edges, with each low phase CAL_HALF system clocks long, and it raises no result_valid.
- R3: A conversion frame has exactly 14 falling edges, with low phases of CONV_HALF clocks. The converter word is 14 bits, most significant first: two framing bits, then the 12-bit result. The first bit is on ser_din when sel_n falls, and each later bit follows a ser_clk falling edge. The host takes each bit just before the falling edge that replaces it. result carries word bits 11..0.
- R4: frame_err is high with result_valid when either of word bits 13 and 12 is one; result still carries word bits 11..0.
- R5: A cal_req yields a frame of exactly 32 falling edges with low phases of CAL_HALF clocks, and that frame returns its first 14 bits as a valid conversion.
- R6: A cal_req that arrives during a frame does not disturb that frame; the calibration frame follows as the next frame.
- R7: conv_req is ignored while busy is high: it neither starts nor queues a frame.
- R8: At least SETUP_CYC clocks pass from sel_n falling to the first ser_clk fall, and more than HOLD_CYC clocks pass from the last fall to sel_n rising.
- R9: Between frames, sel_n stays high for at least ACQ_CYC clocks.
- R10: result_valid is a single-cycle pulse, raised in the first cycle of sel_n high after a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_req | input | 1 | Start a conversion frame (taken when busy is low) |
| cal_req | input | 1 | Request a calibration frame (held until issued) |
| busy | output | 1 | A frame is running or pending |
| result | output | 12 | Straight-binary conversion code |
| result_valid | output | 1 | One-cycle strobe for result |
| frame_err | output | 1 | A framing bit was not zero |
| sel_n | output | 1 | Converter select, active low |
| ser_clk | output | 1 | Serial clock, idles high |
| ser_din | input | 1 | Serial data from the converter |

## Verification
The hardest case to reach is a calibration request, or a stray conversion request, that lands inside a running frame. Both requests arrive at the same moment and must be kept apart: one must wait and the other must vanish. The bench watches the serial clock and counts falling edges as they happen. Once a conversion frame is three edges in, it pulses both requests. It then checks that the frame still ends after 14 edges, that a single 32-edge frame follows, and that no third frame appears. Framing errors need a converter model that sets the leading bits on purpose, and the bench steps through each of the three non-zero patterns.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

    typedef enum logic [1:0] {
        K_CONV  = 2'd0,
        K_PWRUP = 2'd1,
        K_CAL   = 2'd2
    } frame_kind_t;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_SETUP = 3'd1,
        S_LOW   = 3'd2,
        S_HIGH  = 3'd3,
        S_HOLD  = 3'd4,
        S_ACQ   = 3'd5
    } seq_state_t;

endpackage

// File: rtl/adc_frame_arb.sv
module adc_frame_arb
    import adc_frame_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        conv_req,
    input  logic        cal_req,
    input  logic        seq_idle,
    output logic        start,
    output frame_kind_t start_kind,
    output logic        busy
);

    typedef struct packed {
        logic pwrup;
        logic cal;
    } arb_t;

    arb_t a_d, a_q;

    always_comb begin
        a_d        = a_q;
        start      = 1'b0;
        start_kind = K_CONV;
        busy       = !seq_idle || a_q.pwrup || a_q.cal;

        if (seq_idle) begin
            if (a_q.pwrup) begin
                start      = 1'b1;
                start_kind = K_PWRUP;
                a_d.pwrup  = 1'b0;
            end else if (a_q.cal) begin
                start      = 1'b1;
                start_kind = K_CAL;
                a_d.cal    = 1'b0;
            end else if (conv_req) begin
                start      = 1'b1;
                start_kind = K_CONV;
            end
        end

        if (cal_req) begin
            a_d.cal = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q.pwrup <= 1'b1;
            a_q.cal   <= 1'b0;
        end else begin
            a_q <= a_d;
        end
    end

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
    import adc_frame_pkg::*;
#(
    parameter int CONV_HALF   = 1,
    parameter int CAL_HALF    = 2,
    parameter int SETUP_CYC   = 1,
    parameter int HOLD_CYC    = 1,
    parameter int ACQ_CYC     = 5,
    parameter int WORD_BITS   = 14,
    parameter int PWRUP_EDGES = 16,
    parameter int CAL_EDGES   = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  frame_kind_t start_kind,
    output logic        idle,
    output logic        sel_n,
    output logic        ser_clk,
    output logic        sample,
    output logic        frame_end,
    output frame_kind_t kind
);

    localparam int MAX_A   = (CONV_HALF > CAL_HALF) ? CONV_HALF : CAL_HALF;
    localparam int MAX_B   = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_ALL = (MAX_C > ACQ_CYC) ? MAX_C : ACQ_CYC;
    localparam int CNT_W   = (MAX_ALL < 2) ? 1 : $clog2(MAX_ALL);
    localparam int EDGE_W  = $clog2(CAL_EDGES + 1);

    localparam logic [CNT_W-1:0]  CONV_M1  = CNT_W'(CONV_HALF - 1);
    localparam logic [CNT_W-1:0]  CAL_M1   = CNT_W'(CAL_HALF - 1);
    localparam logic [CNT_W-1:0]  SETUP_M1 = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0]  HOLD_M1  = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0]  ACQ_M1   = CNT_W'(ACQ_CYC - 1);
    localparam logic [EDGE_W-1:0] N_WORD   = EDGE_W'(WORD_BITS);
    localparam logic [EDGE_W-1:0] N_PWRUP  = EDGE_W'(PWRUP_EDGES);
    localparam logic [EDGE_W-1:0] N_CAL    = EDGE_W'(CAL_EDGES);

    typedef struct packed {
        seq_state_t        st;
        frame_kind_t       kind;
        logic [CNT_W-1:0]  cnt;
        logic [EDGE_W-1:0] edges;
        logic              sel_n;
        logic              sclk;
    } seq_t;

    seq_t s_d, s_q;
    logic [CNT_W-1:0]  half_m1;
    logic [EDGE_W-1:0] target;

    always_comb begin
        half_m1 = (s_q.kind == K_CONV) ? CONV_M1 : CAL_M1;
        case (s_q.kind)
            K_PWRUP: target = N_PWRUP;
            K_CAL:   target = N_CAL;
            default: target = N_WORD;
        endcase
    end

    always_comb begin
        s_d       = s_q;
        sample    = 1'b0;
        frame_end = 1'b0;

        case (s_q.st)
            S_IDLE: begin
                if (start) begin
                    s_d.st    = S_SETUP;
                    s_d.kind  = start_kind;
                    s_d.cnt   = SETUP_M1;
                    s_d.edges = '0;
                    s_d.sel_n = 1'b0;
                end
            end
            S_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.st    = S_LOW;
                    s_d.sclk  = 1'b0;
                    s_d.edges = EDGE_W'(1);
                    s_d.cnt   = half_m1;
                    sample    = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            S_LOW: begin
                if (s_q.cnt == '0) begin
                    s_d.st   = S_HIGH;
                    s_d.sclk = 1'b1;
                    s_d.cnt  = half_m1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            S_HIGH: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else if (s_q.edges == target) begin
                    s_d.st  = S_HOLD;
                    s_d.cnt = HOLD_M1;
                end else begin
                    s_d.st    = S_LOW;
                    s_d.sclk  = 1'b0;
                    s_d.edges = s_q.edges + 1'b1;
                    s_d.cnt   = half_m1;
                    sample    = (s_q.edges < N_WORD);
                end
            end
            S_HOLD: begin
                if (s_q.cnt == '0) begin
                    s_d.st    = S_ACQ;
                    s_d.sel_n = 1'b1;
                    s_d.cnt   = ACQ_M1;
                    frame_end = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            S_ACQ: begin
                if (s_q.cnt == '0) begin
                    s_d.st = S_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st    <= S_IDLE;
            s_q.kind  <= K_CONV;
            s_q.cnt   <= '0;
            s_q.edges <= '0;
            s_q.sel_n <= 1'b1;
            s_q.sclk  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign idle    = (s_q.st == S_IDLE);
    assign sel_n   = s_q.sel_n;
    assign ser_clk = s_q.sclk;
    assign kind    = s_q.kind;

endmodule

// File: rtl/adc_frame_capture.sv
module adc_frame_capture
    import adc_frame_pkg::*;
#(
    parameter int RES_BITS  = 12,
    parameter int LEAD_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample,
    input  logic                ser_din,
    input  logic                frame_end,
    input  frame_kind_t         kind,
    output logic [RES_BITS-1:0] result,
    output logic                result_valid,
    output logic                frame_err
);

    localparam int WORD_BITS = RES_BITS + LEAD_BITS;

    typedef struct packed {
        logic [WORD_BITS-1:0] shift;
        logic [RES_BITS-1:0]  res;
        logic                 valid;
        logic                 err;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.valid = 1'b0;
        c_d.err   = 1'b0;
        if (sample) begin
            c_d.shift = {c_q.shift[WORD_BITS-2:0], ser_din};
        end
        if (frame_end && (kind != K_PWRUP)) begin
            c_d.res   = c_q.shift[RES_BITS-1:0];
            c_d.valid = 1'b1;
            c_d.err   = |c_q.shift[WORD_BITS-1:RES_BITS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign result       = c_q.res;
    assign result_valid = c_q.valid;
    assign frame_err    = c_q.err;

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
    import adc_frame_pkg::*;
#(
    parameter int CLK_NS    = 20,
    parameter int CONV_HALF = 1,
    parameter int CAL_HALF  = 2,
    parameter int SETUP_CYC = 1,
    parameter int HOLD_CYC  = 1,
    parameter int ACQ_CYC   = 5,
    parameter int RES_BITS  = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_req,
    input  logic                cal_req,
    output logic                busy,
    output logic [RES_BITS-1:0] result,
    output logic                result_valid,
    output logic                frame_err,
    output logic                sel_n,
    output logic                ser_clk,
    input  logic                ser_din
);

    localparam int LEAD_BITS   = 2;
    localparam int WORD_BITS   = RES_BITS + LEAD_BITS;
    localparam int PWRUP_EDGES = 16;
    localparam int CAL_EDGES   = 32;

    // Serial clock period in ns times the MHz ceiling must reach 1000.
    if (2 * CONV_HALF * CLK_NS * 32 < 1000) begin : g_bad_conv_rate
        $error("conversion serial clock above 32 MHz");
    end
    if (2 * CAL_HALF * CLK_NS * 16 < 1000) begin : g_bad_cal_rate
        $error("calibration serial clock above 16 MHz");
    end
    if (SETUP_CYC * CLK_NS < 12) begin : g_bad_setup
        $error("select setup below 12 ns");
    end
    if (HOLD_CYC * CLK_NS < 10) begin : g_bad_hold
        $error("select hold below 10 ns");
    end
    if (ACQ_CYC * CLK_NS < 90) begin : g_bad_acq
        $error("acquisition gap below 90 ns");
    end

    logic        start;
    frame_kind_t start_kind;
    logic        seq_idle;
    logic        sample;
    logic        frame_end;
    frame_kind_t kind;

    adc_frame_arb u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_req   (conv_req),
        .cal_req    (cal_req),
        .seq_idle   (seq_idle),
        .start      (start),
        .start_kind (start_kind),
        .busy       (busy)
    );

    adc_frame_seq #(
        .CONV_HALF   (CONV_HALF),
        .CAL_HALF    (CAL_HALF),
        .SETUP_CYC   (SETUP_CYC),
        .HOLD_CYC    (HOLD_CYC),
        .ACQ_CYC     (ACQ_CYC),
        .WORD_BITS   (WORD_BITS),
        .PWRUP_EDGES (PWRUP_EDGES),
        .CAL_EDGES   (CAL_EDGES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_kind (start_kind),
        .idle       (seq_idle),
        .sel_n      (sel_n),
        .ser_clk    (ser_clk),
        .sample     (sample),
        .frame_end  (frame_end),
        .kind       (kind)
    );

    adc_frame_capture #(
        .RES_BITS  (RES_BITS),
        .LEAD_BITS (LEAD_BITS)
    ) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample       (sample),
        .ser_din      (ser_din),
        .frame_end    (frame_end),
        .kind         (kind),
        .result       (result),
        .result_valid (result_valid),
        .frame_err    (frame_err)
    );

endmodule

// File: rtl/adc_frame_ctrl_chk.sv
module adc_frame_ctrl_chk #(
    parameter int ACQ_CYC = 5
) (
    input logic clk,
    input logic rst_n,
    input logic sel_n,
    input logic ser_clk,
    input logic busy,
    input logic result_valid,
    input logic frame_err
);

    logic [7:0]  falls_q;
    logic [15:0] gap_q;
    logic        sclk_p;
    logic        seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            falls_q <= '0;
            gap_q   <= '0;
            sclk_p  <= 1'b1;
            seen_q  <= 1'b0;
        end else begin
            sclk_p <= ser_clk;
            if (sel_n) begin
                falls_q <= '0;
                if (gap_q != 16'hFFFF) gap_q <= gap_q + 1'b1;
            end else begin
                gap_q  <= '0;
                seen_q <= 1'b1;
                if (sclk_p && !ser_clk) falls_q <= falls_q + 1'b1;
            end
        end
    end

    // R1: serial clock rests high whenever the converter is deselected
    assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> ser_clk);

    // R7: an open frame always reports busy
    assert_busy_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_n |-> busy);

    // R10: valid lasts one cycle
    assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R10: valid coincides with the deselect edge
    assert_valid_at_close_R10: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $rose(sel_n));

    // R4: error only qualifies a delivered word
    assert_err_qualified_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> result_valid);

    // R2 R3 R5: every frame closes after one of the three legal edge counts
    assert_edge_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_n) |-> (falls_q == 8'd14 || falls_q == 8'd16 || falls_q == 8'd32));

    // R9: deselect gap before every frame after the first
    assert_acq_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sel_n) && seen_q) |-> (gap_q >= 16'(ACQ_CYC)));

endmodule

bind adc_frame_ctrl adc_frame_ctrl_chk #(.ACQ_CYC(ACQ_CYC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_n        (sel_n),
    .ser_clk      (ser_clk),
    .busy         (busy),
    .result_valid (result_valid),
    .frame_err    (frame_err)
);

// File: tb/sim_adc_frame_ctrl.sv
`timescale 1ns/1ps
module sim_adc_frame_ctrl;

    localparam int CONV_HALF = 1;
    localparam int CAL_HALF  = 2;
    localparam int SETUP_CYC = 1;
    localparam int HOLD_CYC  = 1;
    localparam int ACQ_CYC   = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_req = 1'b0;
    logic        cal_req = 1'b0;
    logic        busy;
    logic [11:0] result;
    logic        result_valid;
    logic        frame_err;
    logic        sel_n;
    logic        ser_clk;
    logic        ser_din = 1'b0;

    always #10 clk = ~clk;

    adc_frame_ctrl #(
        .CLK_NS    (20),
        .CONV_HALF (CONV_HALF),
        .CAL_HALF  (CAL_HALF),
        .SETUP_CYC (SETUP_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .ACQ_CYC   (ACQ_CYC),
        .RES_BITS  (12)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .conv_req     (conv_req),
        .cal_req      (cal_req),
        .busy         (busy),
        .result       (result),
        .result_valid (result_valid),
        .frame_err    (frame_err),
        .sel_n        (sel_n),
        .ser_clk      (ser_clk),
        .ser_din      (ser_din)
    );

    // converter model: first bit at select fall, next bit after each clock fall
    logic [13:0] dev_word = 14'h0;
    int          dev_idx  = 0;
    always @(negedge sel_n or negedge ser_clk) begin
        if (!sel_n && ser_clk) begin
            dev_idx = 0;
            ser_din = dev_word[13];
        end else if (!sel_n) begin
            dev_idx = dev_idx + 1;
            ser_din = (dev_idx < 14) ? dev_word[13 - dev_idx] : 1'b0;
        end
    end

    // port monitor
    int frames = 0, live_edges = 0, last_edges = 0;
    int setup_n = 0, last_setup = 0, tail_n = 0, last_tail = 0;
    int lowrun = 0, minlow = 0, maxlow = 0, last_minlow = 0, last_maxlow = 0;
    int gap = 0, mingap = 1000000;
    int vcount = 0, vres = 0, verr = 0;
    logic prev_cs = 1'b1, prev_sclk = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!sel_n) begin
                if (prev_cs) begin
                    if (frames > 0 && gap < mingap) mingap = gap;
                    live_edges = 0; setup_n = 0; tail_n = 0;
                    lowrun = 0; minlow = 1000; maxlow = 0;
                end
                if (!ser_clk && prev_sclk) begin
                    live_edges = live_edges + 1;
                    tail_n = 0;
                end
                if (!ser_clk) begin
                    lowrun = lowrun + 1;
                end else if (!prev_sclk) begin
                    if (lowrun < minlow) minlow = lowrun;
                    if (lowrun > maxlow) maxlow = lowrun;
                    lowrun = 0;
                end
                if (live_edges == 0) setup_n = setup_n + 1;
                tail_n = tail_n + 1;
            end else if (!prev_cs) begin
                last_edges = live_edges; last_setup = setup_n; last_tail = tail_n;
                last_minlow = minlow; last_maxlow = maxlow;
                frames = frames + 1;
                gap = 1;
            end else begin
                gap = gap + 1;
            end
            if (result_valid) begin
                vcount = vcount + 1;
                vres = int'(result);
                verr = int'(frame_err);
            end
        end
        prev_cs = sel_n;
        prev_sclk = ser_clk;
    end

    int  checks = 0, failures = 0;
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_frame();
        int n = frames;
        while (frames == n) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic run_conv(input logic [13:0] w);
        int v0;
        wait_idle();
        dev_word = w;
        v0 = vcount;
        conv_req = 1'b1;
        @(negedge clk);
        conv_req = 1'b0;
        wait_frame();
        chk(vcount == v0 + 1, "R10 one valid per conversion", vcount - v0, 1);
        chk(vres == int'(w[11:0]), "R3 result code", vres, int'(w[11:0]));
        chk(verr == int'(|w[13:12]), "R4 framing flag", verr, int'(|w[13:12]));
        chk(last_edges == 14, "R3 conversion edge count", last_edges, 14);
    endtask

    initial begin
        dev_word = 14'h0ABC;
        repeat (3) @(negedge clk);
        chk(sel_n == 1'b1, "R1 sel_n in reset", int'(sel_n), 1);
        chk(ser_clk == 1'b1, "R1 ser_clk in reset", int'(ser_clk), 1);
        chk(result_valid == 1'b0, "R1 valid in reset", int'(result_valid), 0);
        chk(frame_err == 1'b0, "R1 err in reset", int'(frame_err), 0);
        chk(busy == 1'b1, "R1 busy in reset", int'(busy), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R1 busy after reset", int'(busy), 1);

        // R2: automatic power-up calibration frame
        wait_frame();
        chk(last_edges == 16, "R2 power-up edge count", last_edges, 16);
        chk(last_minlow == CAL_HALF && last_maxlow == CAL_HALF, "R2 power-up clock rate",
            last_maxlow, CAL_HALF);
        chk(vcount == 0, "R2 no data from power-up frame", vcount, 0);

        // R3: sweep of codes with clean framing bits
        for (int c = 0; c < 4096; c += 7) begin
            run_conv({2'b00, 12'(c)});
        end
        run_conv(14'h0FFF);
        run_conv(14'h0800);
        chk(last_minlow == CONV_HALF && last_maxlow == CONV_HALF, "R3 conversion clock rate",
            last_maxlow, CONV_HALF);
        chk(last_setup >= SETUP_CYC, "R8 setup", last_setup, SETUP_CYC);
        chk(last_tail > HOLD_CYC, "R8 hold", last_tail, HOLD_CYC + 1);

        // R4: every non-zero framing pattern
        for (int l = 1; l < 4; l++) begin
            run_conv({2'(l), 12'h5A5});
        end

        // R5: calibration on command while idle
        begin
            int v0;
            wait_idle();
            dev_word = 14'h0123;
            v0 = vcount;
            cal_req = 1'b1;
            @(negedge clk);
            cal_req = 1'b0;
            wait_frame();
            chk(last_edges == 32, "R5 calibration edge count", last_edges, 32);
            chk(last_minlow == CAL_HALF && last_maxlow == CAL_HALF, "R5 calibration clock rate",
                last_maxlow, CAL_HALF);
            chk(vcount == v0 + 1, "R5 calibration returns data", vcount - v0, 1);
            chk(vres == 12'h123, "R5 calibration data", vres, 12'h123);
            chk(last_setup >= SETUP_CYC, "R8 setup in calibration", last_setup, SETUP_CYC);
        end

        // R6/R7: cal_req and conv_req land inside a running conversion
        begin
            int f0;
            wait_idle();
            dev_word = 14'h0777;
            f0 = frames;
            conv_req = 1'b1;
            @(negedge clk);
            conv_req = 1'b0;
            while (sel_n || live_edges < 3) @(negedge clk);
            cal_req = 1'b1;
            conv_req = 1'b1;
            @(negedge clk);
            cal_req = 1'b0;
            conv_req = 1'b0;
            wait_frame();
            chk(last_edges == 14, "R6 running frame undisturbed", last_edges, 14);
            chk(vres == 12'h777, "R6 running frame data", vres, 12'h777);
            wait_frame();
            chk(last_edges == 32, "R6 deferred calibration follows", last_edges, 32);
            repeat (80) @(negedge clk);
            chk(frames == f0 + 2, "R7 request while busy dropped", frames - f0, 2);
            chk(busy == 1'b0, "R7 idle after queue drains", int'(busy), 0);
        end

        chk(mingap >= ACQ_CYC, "R9 deselect gap", mingap, ACQ_CYC);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks = checks + 1;
            failures = failures + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule